// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timer

This block holds two identical down-counting timer channels behind one word-addressed register window with 32-bit data. Software programs each channel through its own registers: a reload limit, a readable current count, a control word, an interrupt-clear strobe, raw and masked interrupt status, and a second limit register that changes the reload value without touching the running count. Each channel counts single steps of a shared tick-enable input after a prescaler of 1, 16 or 256. Its counter is either 16 or 32 bits wide. On expiry it either wraps to the full-scale value (free-running) or reloads the programmed limit (periodic). In one-shot mode it parks at zero instead.

Each channel runs a small state machine with three states. ST_OFF means the channel is disabled and the count is frozen. ST_RUN means it is counting prescaled steps. ST_DONE means a one-shot expiry has parked the count at zero. The transitions are named as follows. T_ENABLE goes from ST_OFF to ST_RUN on a control write with enable set. T_DISABLE goes from ST_RUN or ST_DONE to ST_OFF on a control write with enable clear. T_EXPIRE goes from ST_RUN to ST_DONE on an expiry in one-shot mode. T_RESUME goes from ST_DONE to ST_RUN on a control write with enable set. T_RELOAD goes from ST_DONE to ST_RUN on a limit write. An expiry sets the channel's interrupt flag. The two channel interrupts, each gated by its own enable, are ORed onto one output.

Top module: `dual_dtimer`

## Requirements
- R1: After reset each channel's control word reads 0x20 (interrupt enable only, disabled, free-running, 16-bit, divide by 1). Limit, count and raw flag read 0, and irq_out is low.
- R2: Byte offsets within a channel: 0x00 limit, 0x04 current count, 0x08 control, 0x0C interrupt clear, 0x10 raw status, 0x14 masked status, 0x18 background limit. Address bit 5 selects channel 1. Offset 0x1C, the clear offset and any address with bits 1:0 nonzero read 0. Writes to 0x1C or to a misaligned address change nothing.
- R3: Control fields: bit 0 one-shot, bit 1 selects a 32-bit counter (0 gives 16-bit), bits 3:2 prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 enable. Bit 4 and bits 31:8 read 0.
- R4: A write to the limit offset stores the full 32-bit limit and loads the count with it in the next cycle. The loaded count is cut to its low 16 bits in 16-bit mode. A limit write wins over a step in the same cycle. Writes to the count offset are ignored.
- R5: A write to the background-limit offset stores the limit and leaves the count unchanged. The next reload uses the new limit, and both limit offsets read the stored value.
- R6: In ST_RUN each prescaled step decrements the count. A step taken while the count is 1 or 0 is an expiry: it sets the raw flag and reloads the count.
- R7: On expiry in free-running mode the count reloads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode. In periodic mode it reloads the limit, cut to 16 bits in 16-bit mode.
- R8: Prescale 00 (and 11) steps on every tick, 01 on every 16th tick and 10 on every 256th tick. A control write restarts the prescaler phase, so the first step after it comes on the 16th or 256th tick.
- R9: In one-shot mode an expiry parks the count at 0, and further ticks leave it there. A limit write then restarts counting from the new limit.
- R10: Masked status and the channel interrupt equal the raw flag ANDed with interrupt enable. irq_out is the OR of both channel interrupts.
- R11: Any write to the clear offset clears the raw flag. An expiry in the same cycle wins, and the flag stays set.
- R12: With enable clear the count does not change on ticks.
- R13: The channels are independent: activity on one changes no register of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer reference tick, one cycle per count event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en, 0 otherwise |
| irq_out | output | 1 | Merged interrupt of both channels |

## Verification
Two events can meet in the same cycle. An expiry, which sets the flag, can coincide with a software write to the interrupt-clear offset, which lowers it. The bench arranges this by loading a limit of 1 and raising tick_en together with the clear write. It then judges the raw status afterwards: the flag must still read 1, and a later clear on its own must bring it to 0. The same kind of clash between a limit write and a step is watched by a property that requires the loaded limit to appear in the count.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    // Control word layout, most significant field first (bit 7 .. bit 0).
    typedef struct packed {
        logic       enable;    // bit 7
        logic       periodic;  // bit 6
        logic       irq_en;    // bit 5
        logic       rsvd;      // bit 4, always stored as 0
        logic [1:0] prescale;  // bits 3:2
        logic       wide;      // bit 1, 1 = 32-bit counter
        logic       oneshot;   // bit 0
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        enable:   1'b0,
        periodic: 1'b0,
        irq_en:   1'b1,
        rsvd:     1'b0,
        prescale: 2'b00,
        wide:     1'b0,
        oneshot:  1'b0
    };

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    typedef enum logic [2:0] {
        RG_LOAD   = 3'd0,
        RG_VALUE  = 3'd1,
        RG_CTL    = 3'd2,
        RG_CLR    = 3'd3,
        RG_RAW    = 3'd4,
        RG_MASKED = 3'd5,
        RG_BGLOAD = 3'd6,
        RG_NONE   = 3'd7
    } reg_idx_t;

    localparam logic [1:0] PS_DIV1   = 2'b00;
    localparam logic [1:0] PS_DIV16  = 2'b01;
    localparam logic [1:0] PS_DIV256 = 2'b10;

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
    import dtmr_pkg::*;
#(
    parameter int PRE_W    = 8,
    parameter int MID_BITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] mode,
    output logic       step
);

    logic [PRE_W-1:0] phase_q;
    logic             term;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run && tick_en) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            PS_DIV16:  term = &phase_q[MID_BITS-1:0];
            PS_DIV256: term = &phase_q;
            default:   term = 1'b1;
        endcase
        step = run && tick_en && term;
    end

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PRE_W    = 8,
    parameter int MID_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ld_wr,
    input  logic              bg_wr,
    input  logic              ctl_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  reg_idx_t          rd_idx,
    output logic [DATA_W-1:0] rd_val,
    output logic              irq,
    output logic              flag,
    output logic              irq_en,
    output logic              wide,
    output logic [DATA_W-1:0] count,
    output logic [1:0]        state
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    ctl_t               ctl_q;
    ctl_t               wctl;
    run_state_t         st_q, st_d;
    logic [DATA_W-1:0]  limit_q;
    logic [DATA_W-1:0]  count_q, count_d;
    logic [DATA_W-1:0]  reload_val;
    logic               flag_q;
    logic               step;
    logic               expire;

    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic w);
        return w ? v : (v & HALF_MASK);
    endfunction

    assign wctl = ctl_t'({wdata[7:5], 1'b0, wdata[3:0]});

    dtmr_prescale #(
        .PRE_W   (PRE_W),
        .MID_BITS(MID_BITS)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .run    (st_q == ST_RUN),
        .restart(ctl_wr),
        .mode   (ctl_q.prescale),
        .step   (step)
    );

    // An expiry is a step taken from a count of 1 or 0.
    assign expire = step && (count_q[DATA_W-1:1] == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic: T_ENABLE, T_DISABLE, T_EXPIRE, T_RESUME, T_RELOAD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (ctl_wr && wctl.enable) st_d = ST_RUN;              // T_ENABLE
            end
            ST_RUN: begin
                if (ctl_wr) begin
                    st_d = wctl.enable ? ST_RUN : ST_OFF;             // T_DISABLE
                end else if (expire && ctl_q.oneshot && !ld_wr) begin
                    st_d = ST_DONE;                                   // T_EXPIRE
                end
            end
            ST_DONE: begin
                if (ctl_wr) begin
                    st_d = wctl.enable ? ST_RUN : ST_OFF;             // T_RESUME / T_DISABLE
                end else if (ld_wr) begin
                    st_d = ST_RUN;                                    // T_RELOAD
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    // Count datapath
    always_comb begin
        if (ctl_q.periodic) begin
            reload_val = fit(limit_q, ctl_q.wide);
        end else begin
            reload_val = ctl_q.wide ? {DATA_W{1'b1}} : HALF_MASK;
        end

        count_d = count_q;
        if (ld_wr) begin
            count_d = fit(wdata, ctl_q.wide);
        end else if (expire) begin
            count_d = ctl_q.oneshot ? '0 : reload_val;
        end else if (step) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= CTL_RESET;
            limit_q <= '0;
            count_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            if (ctl_wr) ctl_q <= wctl;
            if (ld_wr || bg_wr) limit_q <= wdata;
            if (expire) begin
                flag_q <= 1'b1;
            end else if (clr_wr) begin
                flag_q <= 1'b0;
            end
        end
    end

    // Output process
    always_comb begin
        unique case (rd_idx)
            RG_LOAD, RG_BGLOAD: rd_val = limit_q;
            RG_VALUE:           rd_val = count_q;
            RG_CTL:             rd_val = {{(DATA_W-8){1'b0}}, ctl_q};
            RG_RAW:             rd_val = {{(DATA_W-1){1'b0}}, flag_q};
            RG_MASKED:          rd_val = {{(DATA_W-1){1'b0}}, flag_q & ctl_q.irq_en};
            default:            rd_val = '0;
        endcase
        irq    = flag_q && ctl_q.irq_en;
        flag   = flag_q;
        irq_en = ctl_q.irq_en;
        wide   = ctl_q.wide;
        count  = count_q;
        state  = st_q;
    end

endmodule

// File: rtl/dtmr_busdec.sv
module dtmr_busdec
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  rd_vals,
    output reg_idx_t                       rd_idx,
    output logic [NUM_CH-1:0]              ld_wr,
    output logic [NUM_CH-1:0]              bg_wr,
    output logic [NUM_CH-1:0]              ctl_wr,
    output logic [NUM_CH-1:0]              clr_wr,
    output logic [DATA_W-1:0]              rdata
);

    localparam int CH_LSB  = 5;
    localparam int CH_BITS = ADDR_W - CH_LSB;

    logic [CH_BITS-1:0] ch;
    logic               aligned;
    logic               hit;

    assign ch      = addr[ADDR_W-1:CH_LSB];
    assign aligned = (addr[1:0] == 2'b00);
    assign rd_idx  = reg_idx_t'(addr[4:2]);
    assign hit     = aligned && (rd_idx != RG_NONE);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
        logic mine;
        assign mine      = wr_en && hit && (ch == CH_BITS'(c));
        assign ld_wr[c]  = mine && (rd_idx == RG_LOAD);
        assign bg_wr[c]  = mine && (rd_idx == RG_BGLOAD);
        assign ctl_wr[c] = mine && (rd_idx == RG_CTL);
        assign clr_wr[c] = mine && (rd_idx == RG_CLR);
    end

    assign rdata = (rd_en && hit) ? rd_vals[ch] : '0;

endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
    import dtmr_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int PRE_W    = 8,
    parameter int MID_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);

    localparam int NUM_CH = 2 ** (ADDR_W - 5);

    reg_idx_t                      rd_idx;
    logic [NUM_CH-1:0]             ld_wr, bg_wr, ctl_wr, clr_wr;
    logic [NUM_CH-1:0][DATA_W-1:0] rd_vals;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_count;
    logic [NUM_CH-1:0][1:0]        ch_state;
    logic [NUM_CH-1:0]             ch_irq, ch_flag, ch_ie, ch_wide;

    dtmr_busdec #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .NUM_CH(NUM_CH)
    ) u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rd_vals(rd_vals),
        .rd_idx (rd_idx),
        .ld_wr  (ld_wr),
        .bg_wr  (bg_wr),
        .ctl_wr (ctl_wr),
        .clr_wr (clr_wr),
        .rdata  (rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dtmr_channel #(
            .DATA_W  (DATA_W),
            .PRE_W   (PRE_W),
            .MID_BITS(MID_BITS)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .ld_wr  (ld_wr[c]),
            .bg_wr  (bg_wr[c]),
            .ctl_wr (ctl_wr[c]),
            .clr_wr (clr_wr[c]),
            .wdata  (wdata),
            .rd_idx (rd_idx),
            .rd_val (rd_vals[c]),
            .irq    (ch_irq[c]),
            .flag   (ch_flag[c]),
            .irq_en (ch_ie[c]),
            .wide   (ch_wide[c]),
            .count  (ch_count[c]),
            .state  (ch_state[c])
        );
    end

    assign irq_out = |ch_irq;

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic                           rd_en,
    input logic [ADDR_W-1:0]              addr,
    input logic [DATA_W-1:0]              wdata,
    input logic [DATA_W-1:0]              rdata,
    input logic                           irq_out,
    input logic [NUM_CH-1:0][DATA_W-1:0]  ch_count,
    input logic [NUM_CH-1:0][1:0]         ch_state,
    input logic [NUM_CH-1:0]              ch_flag,
    input logic [NUM_CH-1:0]              ch_ie,
    input logic [NUM_CH-1:0]              ch_wide
);

    localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h00)) |=>
        ch_count[0] == ($past(ch_wide[0]) ? $past(wdata) : ($past(wdata) & HALF_MASK))); // R4

    AST_VALUE_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h04) && ch_state[0] == ST_OFF) |=> $stable(ch_count[0])); // R4

    AST_BG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h18) && ch_state[0] == ST_OFF) |=> $stable(ch_count[0])); // R5

    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_state[0] == ST_DONE) |-> (ch_count[0] == '0)); // R9

    AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8'h14) && !ch_ie[0]) |-> (rdata == '0)); // R10

    AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(ch_flag & ch_ie))); // R10

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_state[0] == ST_OFF && !wr_en) |=> $stable(ch_count[0])); // R12

endmodule

bind dual_dtimer dtmr_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_CH(NUM_CH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_out (irq_out),
    .ch_count(ch_count),
    .ch_state(ch_state),
    .ch_flag (ch_flag),
    .ch_ie   (ch_ie),
    .ch_wide (ch_wide)
);

// File: tb/sim_dual_dtimer.sv
`timescale 1ns/1ps
module sim_dual_dtimer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dual_dtimer u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .irq_out(irq_out)
    );

    // Expected-value functions
    function automatic logic [31:0] exp_ctl(input logic [31:0] v);
        return v & 32'h0000_00EF;
    endfunction

    function automatic logic [31:0] exp_fit(input logic [31:0] v, input bit w32);
        return w32 ? v : (v & 32'h0000_FFFF);
    endfunction

    function automatic logic [31:0] exp_periodic(input int lim, input int k);
        return 32'(lim - (k % lim));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chkrd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic tick_with_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chkrd("R1 ctl0", 6'h08, 32'h20);
        chkrd("R1 val0", 6'h04, 32'h0);
        chkrd("R1 lim0", 6'h00, 32'h0);
        chkrd("R1 raw0", 6'h10, 32'h0);
        chkrd("R1 ctl1", 6'h28, 32'h20);
        @(negedge clk);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);

        // R4 load in 16-bit mode, value write ignored
        wr(6'h00, 32'h0001_2345);
        chkrd("R4 val16", 6'h04, 32'h0000_2345);
        chkrd("R4 lim", 6'h00, 32'h0001_2345);
        wr(6'h04, 32'hDEAD_BEEF);
        chkrd("R4 val ro", 6'h04, 32'h0000_2345);

        // R2 unmapped and misaligned
        wr(6'h1C, 32'h55);
        wr(6'h01, 32'hFF);
        chkrd("R2 unmapped rd", 6'h1C, 32'h0);
        chkrd("R2 clr rd", 6'h0C, 32'h0);
        chkrd("R2 misaligned rd", 6'h01, 32'h0);
        chkrd("R2 ctl kept", 6'h08, 32'h20);
        chkrd("R2 val kept", 6'h04, 32'h0000_2345);

        // R3 random control readback (enable kept clear)
        for (int i = 0; i < 4; i++) begin
            logic [31:0] v;
            v = $urandom & 32'hFFFF_FF7F;
            wr(6'h08, v);
            chkrd("R3 ctl readback", 6'h08, exp_ctl(v));
        end
        wr(6'h08, 32'h20);

        // R7 free-running 16-bit
        wr(6'h00, 32'd3);
        wr(6'h08, 32'hA0);
        tick(3);
        chkrd("R7 free16 wrap", 6'h04, 32'h0000_FFFF);
        chkrd("R6 raw set", 6'h10, 32'h1);
        tick(1);
        chkrd("R6 decrement", 6'h04, 32'h0000_FFFE);

        // R7 free-running 32-bit
        wr(6'h08, 32'h22);
        wr(6'h00, 32'd2);
        wr(6'h08, 32'hA2);
        tick(2);
        chkrd("R7 free32 wrap", 6'h04, 32'hFFFF_FFFF);

        // R10 masking
        wr(6'h08, 32'h02);
        chkrd("R10 raw", 6'h10, 32'h1);
        chkrd("R10 masked off", 6'h14, 32'h0);
        @(negedge clk);
        chk("R10 irq masked", {31'b0, irq_out}, 32'h0);
        wr(6'h08, 32'h22);
        chkrd("R10 masked on", 6'h14, 32'h1);
        @(negedge clk);
        chk("R10 irq on", {31'b0, irq_out}, 32'h1);

        // R11 clear
        wr(6'h0C, 32'h0);
        chkrd("R11 cleared", 6'h10, 32'h0);
        @(negedge clk);
        chk("R11 irq low", {31'b0, irq_out}, 32'h0);

        // R11 expiry and clear in the same cycle: set wins
        wr(6'h08, 32'h60);
        wr(6'h00, 32'd1);
        wr(6'h08, 32'hE0);
        tick_with_write(6'h0C, 32'h0);
        chkrd("R11 set wins", 6'h10, 32'h1);
        wr(6'h0C, 32'h0);
        chkrd("R11 clear after", 6'h10, 32'h0);

        // R6 R7 random periodic runs
        for (int i = 0; i < 6; i++) begin
            int lim;
            int k;
            lim = 2 + int'($urandom % 30);
            k   = int'($urandom % 70);
            wr(6'h08, 32'h60);
            wr(6'h00, 32'(lim));
            wr(6'h0C, 32'h0);
            wr(6'h08, 32'hE0);
            tick(k);
            chkrd("R7 periodic count", 6'h04, exp_periodic(lim, k));
            chkrd("R6 periodic flag", 6'h10, (k >= lim) ? 32'h1 : 32'h0);
        end

        // R8 prescale by 16 and 256
        wr(6'h08, 32'h64);
        wr(6'h00, 32'd10);
        wr(6'h08, 32'hE4);
        tick(15);
        chkrd("R8 div16 hold", 6'h04, 32'd10);
        tick(1);
        chkrd("R8 div16 step", 6'h04, 32'd9);
        wr(6'h08, 32'h68);
        wr(6'h00, 32'd10);
        wr(6'h08, 32'hE8);
        tick(255);
        chkrd("R8 div256 hold", 6'h04, 32'd10);
        tick(1);
        chkrd("R8 div256 step", 6'h04, 32'd9);

        // R5 background limit
        wr(6'h08, 32'h60);
        wr(6'h00, 32'd4);
        wr(6'h08, 32'hE0);
        tick(1);
        wr(6'h18, 32'd8);
        chkrd("R5 count kept", 6'h04, 32'd3);
        chkrd("R5 lim rd", 6'h00, 32'd8);
        chkrd("R5 bg rd", 6'h18, 32'd8);
        tick(3);
        chkrd("R5 new reload", 6'h04, 32'd8);

        // R9 one-shot, R12 disable
        wr(6'h08, 32'h61);
        wr(6'h00, 32'd2);
        wr(6'h0C, 32'h0);
        wr(6'h08, 32'hE1);
        tick(2);
        chkrd("R9 parked", 6'h04, 32'd0);
        chkrd("R9 flag", 6'h10, 32'h1);
        tick(3);
        chkrd("R9 stays", 6'h04, 32'd0);
        wr(6'h00, 32'd5);
        tick(1);
        chkrd("R9 restart", 6'h04, 32'd4);
        wr(6'h08, 32'h61);
        tick(4);
        chkrd("R12 frozen", 6'h04, 32'd4);

        // R13 channel 1 independent, R10 merge
        wr(6'h08, 32'h20);
        wr(6'h0C, 32'h0);
        wr(6'h20, 32'd2);
        wr(6'h28, 32'hE0);
        tick(2);
        chkrd("R13 ch1 raw", 6'h30, 32'h1);
        chkrd("R13 ch0 raw", 6'h10, 32'h0);
        chkrd("R13 ch0 val", 6'h04, 32'd4);
        chkrd("R13 ch1 val", 6'h24, 32'd2);
        @(negedge clk);
        chk("R10 merged irq", {31'b0, irq_out}, 32'h1);
        wr(6'h2C, 32'h0);
        @(negedge clk);
        chk("R10 merged low", {31'b0, irq_out}, 32'h0);
        chk("R4 fit check", exp_fit(32'h0001_2345, 1'b0), 32'h0000_2345);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule